// File: doc/BRIEF.md
# SDRAM Bank State and Precharge Tracker

This block watches the command stream that a memory controller sends to an SDRAM device with four banks. It keeps, for each bank, whether a row is open, whether the bank is recovering from a precharge, or whether it is idle. It reports that status on two per-bank vectors. It also flags any command the device would not accept. Examples are a read or write to a bank with no open row, an activate to a bank that already has a row open, and any access to a bank that is still inside its precharge recovery window.

Three kinds of precharge are modelled: an explicit precharge of one bank, an explicit precharge of all banks, and auto precharge. Auto precharge is requested per read or write through the A10 bit. It starts on its own at the end of the burst, and it blocks the bank for the same recovery time as an explicit precharge. The burst length is a configuration input. In full-page mode a burst runs until it is ended, and the auto-precharge request is ignored. A burst-stop command ends the most recent burst early.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank reads not open and not busy, and the error output is low.
- R2: An activate (command code 1) to an idle bank sets that bank's open bit from the next cycle. An activate to a bank that is open or busy is illegal.
- R3: A read (code 2) or write (code 3) to a bank whose open bit is low is illegal.
- R4: An illegal command raises `err_o` for exactly the next cycle, with `err_bank_o` set to the offending bank. The illegal command changes no bank's state.
- R5: A precharge (code 4) with A10 low closes only the addressed open bank. Its open bit drops and its busy bit is high for TRP-1 cycles, so an activate is accepted TRP cycles after the precharge. Other banks are unchanged.
- R6: A precharge with A10 high closes every open bank whatever the bank bits are, and leaves idle banks idle and not busy.
- R7: Any activate, read, write or precharge addressed to a busy bank is illegal. An all-bank precharge is illegal while any bank is busy, and reports the lowest such bank.
- R8: A read or write with A10 high and burst length L (`bl_sel_i` 0, 1, 2 giving 2, 4, 8) keeps the row open for L cycles after the command. The bank then closes and is busy for TRP-1 cycles, exactly as if a precharge had been issued L cycles after the command.
- R9: While an auto-precharge burst is running, any command addressed to its bank is illegal.
- R10: The A10 setting applies only to its own command. A later read or write with A10 low leaves the row open indefinitely.
- R11: With `bl_sel_i` = 3 (full page) the burst has no end, A10 on a read or write has no effect, and the row stays open.
- R12: A burst stop (code 5, bank bits ignored) ends the running burst. A read or write to another bank replaces it. In both cases a pending auto precharge starts at that command, and the bank is busy from the next cycle.
- R13: A single-bank precharge of an idle bank is legal and changes nothing. Codes 0, 6 and 7 are no-operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop |
| bank_i | input | 2 | Addressed bank |
| a10_i | input | 1 | All-bank select on precharge; auto-precharge request on read or write |
| bl_sel_i | input | 2 | Burst length: 0 two, 1 four, 2 eight, 3 full page |
| bank_open_o | output | 4 | Per-bank row-open status |
| bank_busy_o | output | 4 | Per-bank precharge recovery in progress |
| err_o | output | 1 | One-cycle pulse after an illegal command |
| err_bank_o | output | 2 | Bank that made the last command illegal |

## Verification
The assertions assume that `bl_sel_i` holds steady during a burst. They also assume the command inputs are settled at each rising edge. Under those conditions a bank's open and busy bits follow only the legal commands. The stimulus changes the inputs only a short time after a rising edge, and it changes the burst length only while no burst is running. Illegal commands are driven on purpose, one per case, so that every error path is exercised without losing the expected bank state.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;
  localparam logic [2:0] CMD_NOP = 3'd0;
  localparam logic [2:0] CMD_ACT = 3'd1;
  localparam logic [2:0] CMD_RD  = 3'd2;
  localparam logic [2:0] CMD_WR  = 3'd3;
  localparam logic [2:0] CMD_PRE = 3'd4;
  localparam logic [2:0] CMD_BST = 3'd5;

  localparam logic [1:0] BL_FULL = 2'd3;

  // burst beats for the fixed-length codes: 2, 4, 8
  function automatic logic [3:0] burst_beats(logic [1:0] sel);
    return 4'd2 << sel;
  endfunction
endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int TRP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic close_req,
  output logic is_open,
  output logic busy
);
  localparam int TW = (TRP > 2) ? $clog2(TRP) : 1;

  logic          open_q, open_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    open_d = open_q;
    tmr_d  = tmr_q;
    if (tmr_q != '0) tmr_d = tmr_q - 1'b1;
    if (close_req) begin
      open_d = 1'b0;
      tmr_d  = TW'(TRP - 1);
    end else if (open_req) begin
      open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      open_q <= open_d;
      tmr_q  <= tmr_d;
    end
  end

  assign is_open = open_q;
  assign busy    = (tmr_q != '0);
endmodule

// File: rtl/sdram_burst_tracker.sv
module sdram_burst_tracker
  import sdram_bank_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              start_ap,
  input  logic [1:0]        start_sel,
  input  logic              stop,
  output logic              active_o,
  output logic              ap_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              ap_fire_o
);
  logic              act_q, act_d;
  logic              full_q, full_d;
  logic              ap_q, ap_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [2:0]        rem_q, rem_d;
  logic              last_beat;

  assign last_beat = act_q && !full_q && (rem_q == '0);
  // a pending auto precharge starts when the burst ends, is stopped or replaced
  assign ap_fire_o = act_q && ap_q && (last_beat || stop || start);

  always_comb begin
    act_d  = act_q;
    full_d = full_q;
    ap_d   = ap_q;
    bank_d = bank_q;
    rem_d  = rem_q;
    if (start) begin
      act_d  = 1'b1;
      full_d = (start_sel == BL_FULL);
      ap_d   = start_ap && (start_sel != BL_FULL);
      bank_d = start_bank;
      rem_d  = 3'(burst_beats(start_sel) - 4'd1);
    end else if (act_q && (stop || last_beat)) begin
      act_d = 1'b0;
      ap_d  = 1'b0;
    end else if (act_q && !full_q) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      rem_q  <= '0;
    end else begin
      act_q  <= act_d;
      full_q <= full_d;
      ap_q   <= ap_d;
      bank_q <= bank_d;
      rem_q  <= rem_d;
    end
  end

  assign active_o = act_q;
  assign ap_o     = ap_q;
  assign bank_o   = bank_q;
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                         a10_i,
  input  logic [1:0]                   bl_sel_i,
  output logic [NUM_BANKS-1:0]         bank_open_o,
  output logic [NUM_BANKS-1:0]         bank_busy_o,
  output logic                         err_o,
  output logic [$clog2(NUM_BANKS)-1:0] err_bank_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [NUM_BANKS-1:0] is_open, busy, locked, open_req, pre_req, close_req, bad;
  logic                 brst_act, brst_ap, ap_fire, brst_start, brst_stop;
  logic [BANK_W-1:0]    brst_bank;
  logic                 illegal;
  logic [BANK_W-1:0]    ill_bank;
  logic                 err_q, err_d;
  logic [BANK_W-1:0]    err_bank_q, err_bank_d;

  sdram_burst_tracker #(.BANK_W(BANK_W)) burst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (brst_start),
    .start_bank(bank_i),
    .start_ap  (a10_i),
    .start_sel (bl_sel_i),
    .stop      (brst_stop),
    .active_o  (brst_act),
    .ap_o      (brst_ap),
    .bank_o    (brst_bank),
    .ap_fire_o (ap_fire)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign locked[b]    = brst_act && brst_ap && (brst_bank == BANK_W'(b));
    assign close_req[b] = pre_req[b] || (ap_fire && (brst_bank == BANK_W'(b)));
    sdram_bank_timer #(.TRP(TRP)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_req (open_req[b]),
      .close_req(close_req[b]),
      .is_open  (is_open[b]),
      .busy     (busy[b])
    );
  end

  // command decode and legality
  always_comb begin
    open_req   = '0;
    pre_req    = '0;
    brst_start = 1'b0;
    brst_stop  = 1'b0;
    illegal    = 1'b0;
    ill_bank   = bank_i;
    bad        = busy | locked;
    case (cmd_i)
      CMD_ACT: begin
        if (is_open[bank_i] || busy[bank_i]) illegal = 1'b1;
        else open_req[bank_i] = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if (!is_open[bank_i] || locked[bank_i]) illegal = 1'b1;
        else brst_start = 1'b1;
      end
      CMD_PRE: begin
        if (a10_i) begin
          if (bad != '0) begin
            illegal = 1'b1;
            for (int i = NUM_BANKS - 1; i >= 0; i--)
              if (bad[i]) ill_bank = BANK_W'(i);
          end else begin
            pre_req = is_open;
          end
        end else if (bad[bank_i]) begin
          illegal = 1'b1;
        end else begin
          pre_req[bank_i] = is_open[bank_i];
        end
      end
      CMD_BST: brst_stop = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    err_d      = illegal;
    err_bank_d = err_bank_q;
    if (illegal) err_bank_d = ill_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      err_bank_q <= '0;
    end else begin
      err_q      <= err_d;
      err_bank_q <= err_bank_d;
    end
  end

  assign bank_open_o = is_open;
  assign bank_busy_o = busy;
  assign err_o       = err_q;
  assign err_bank_o  = err_bank_q;
endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk
  import sdram_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [2:0]                   cmd_i,
  input logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input logic                         a10_i,
  input logic [NUM_BANKS-1:0]         bank_open_o,
  input logic [NUM_BANKS-1:0]         bank_busy_o,
  input logic                         err_o,
  input logic [$clog2(NUM_BANKS)-1:0] err_bank_o
);
  assert_open_busy_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_open_o & bank_busy_o) == '0);

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_ACT && !bank_open_o[bank_i] && !bank_busy_o[bank_i])
    |=> bank_open_o[$past(bank_i)] && !err_o);

  assert_access_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == CMD_RD || cmd_i == CMD_WR) && !bank_open_o[bank_i])
    |=> err_o && err_bank_o == $past(bank_i));

  assert_busy_cmd_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == CMD_ACT || cmd_i == CMD_RD || cmd_i == CMD_WR || cmd_i == CMD_PRE)
     && bank_busy_o[bank_i]) |=> err_o);

  assert_preall_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_PRE && a10_i) |=> (err_o || bank_open_o == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    assert_busy_no_reopen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bank_busy_o[b] |=> !bank_open_o[b]);
  end
endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_i      (cmd_i),
  .bank_i     (bank_i),
  .a10_i      (a10_i),
  .bank_open_o(bank_open_o),
  .bank_busy_o(bank_busy_o),
  .err_o      (err_o),
  .err_bank_o (err_bank_o)
);

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb_top;
  localparam int TRP = 3;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, BST = 3'd5;

  logic       clk, rst_n, a10;
  logic [2:0] cmd;
  logic [1:0] bank, bl;
  logic [3:0] open_v, busy_v;
  logic       err;
  logic [1:0] err_bank;
  int         nchk, nfail;
  bit         done;

  sdram_bank_tracker #(.NUM_BANKS(4), .TRP(TRP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .a10_i(a10),
    .bl_sel_i(bl), .bank_open_o(open_v), .bank_busy_o(busy_v),
    .err_o(err), .err_bank_o(err_bank)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [2:0] c, int b, bit a);
    cmd = c; bank = 2'(b); a10 = a;
    @(posedge clk); #2;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) cyc(NOP, 0, 1'b0);
  endtask

  initial begin
    nchk = 0; nfail = 0; done = 0;
    cmd = NOP; bank = 0; a10 = 0; bl = 0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 open", int'(open_v), 0);
    chk("R1 busy", int'(busy_v), 0);
    chk("R1 err", int'(err), 0);

    // R2 activate each bank, then a second activate is refused
    for (int b = 0; b < 4; b++) begin
      cyc(ACT, b, 1'b0);
      chk("R2 open bit", int'(open_v[b]), 1);
      chk("R2 legal", int'(err), 0);
      cyc(ACT, b, 1'b0);
      chk("R2 reopen err", int'(err), 1);
      chk("R4 err bank", int'(err_bank), b);
      chk("R4 state kept", int'(open_v[b]), 1);
      nop(1);
      chk("R4 single pulse", int'(err), 0);
    end

    // R6 all-bank precharge, bank bits ignored
    cyc(PRE, 2, 1'b1);
    chk("R6 all closed", int'(open_v), 0);
    chk("R6 all busy", int'(busy_v), 15);
    nop(TRP - 1);
    chk("R6 recovered", int'(busy_v), 0);

    // R3 access to closed banks
    for (int b = 0; b < 4; b++) begin
      cyc((b % 2) ? WR : RD, b, 1'b0);
      chk("R3 err", int'(err), 1);
      chk("R3 err bank", int'(err_bank), b);
    end

    // R13 precharge of idle bank
    cyc(PRE, 3, 1'b0);
    chk("R13 no err", int'(err), 0);
    chk("R13 not busy", int'(busy_v), 0);
    cyc(3'd6, 1, 1'b1);
    chk("R13 code6 nop", int'(err), 0);

    // R7 every command to a busy bank
    cyc(ACT, 0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      cyc(ACT, 2, 1'b0);
      cyc(PRE, 2, 1'b0);
      case (i)
        0: cyc(ACT, 2, 1'b0);
        1: cyc(RD, 2, 1'b0);
        2: cyc(WR, 2, 1'b0);
        3: cyc(PRE, 2, 1'b0);
        default: cyc(PRE, 0, 1'b1);
      endcase
      chk("R7 busy err", int'(err), 1);
      chk("R7 err bank", int'(err_bank), 2);
      nop(TRP);
    end
    chk("R4 bank0 kept open", int'(open_v), 1);

    // R5 single precharge timing
    cyc(ACT, 2, 1'b0);
    cyc(PRE, 2, 1'b0);
    chk("R5 open after pre", int'(open_v), 1);
    chk("R5 busy after pre", int'(busy_v), 4);
    nop(TRP - 2);
    chk("R5 still busy", int'(busy_v[2]), 1);
    nop(1);
    chk("R5 recovered", int'(busy_v[2]), 0);
    cyc(ACT, 2, 1'b0);
    chk("R5 act accepted", int'(err), 0);
    chk("R5 reopened", int'(open_v), 5);

    // R8/R9 sweep over burst lengths and banks
    cyc(PRE, 0, 1'b1);
    nop(TRP);
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 4; b++) begin
        int L;
        L = 2 << s;
        bl = 2'(s);
        cyc(ACT, b, 1'b0);
        cyc((b % 2) ? WR : RD, b, 1'b1);
        chk("R8 open at cmd", int'(open_v[b]), 1);
        for (int k = 1; k < L; k++) begin
          if (k == 1) begin
            cyc(WR, b, 1'b0);
            chk("R9 locked err", int'(err), 1);
            chk("R9 err bank", int'(err_bank), b);
          end else begin
            nop(1);
          end
          chk("R8 open in burst", int'(open_v[b]), 1);
        end
        nop(1);
        chk("R8 closed at end", int'(open_v[b]), 0);
        chk("R8 busy at end", int'(busy_v[b]), 1);
        nop(TRP - 1);
        chk("R8 recovered", int'(busy_v[b]), 0);
      end
    end

    // R10 A10 only for its own command
    bl = 0;
    cyc(ACT, 1, 1'b0);
    cyc(RD, 1, 1'b1);
    nop(2 + TRP - 1);
    cyc(ACT, 1, 1'b0);
    cyc(RD, 1, 1'b0);
    nop(6);
    chk("R10 row stays open", int'(open_v[1]), 1);

    // R11 full page ignores auto precharge
    bl = 3;
    cyc(RD, 1, 1'b1);
    nop(20);
    chk("R11 open", int'(open_v[1]), 1);
    chk("R11 not busy", int'(busy_v[1]), 0);
    cyc(BST, 0, 1'b0);
    nop(2);
    chk("R11 open after stop", int'(open_v[1]), 1);

    // R12 stop and replacement start the pending precharge
    bl = 2;
    cyc(RD, 1, 1'b1);
    nop(2);
    cyc(BST, 3, 1'b0);
    chk("R12 stop closes", int'(open_v[1]), 0);
    chk("R12 stop busy", int'(busy_v[1]), 1);
    nop(TRP);
    cyc(ACT, 0, 1'b0);
    cyc(ACT, 1, 1'b0);
    cyc(RD, 0, 1'b1);
    nop(1);
    cyc(RD, 1, 1'b0);
    chk("R12 replace err", int'(err), 0);
    chk("R12 old bank busy", int'(busy_v[0]), 1);
    chk("R12 old bank closed", int'(open_v[0]), 0);
    chk("R12 new bank open", int'(open_v[1]), 1);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule